// File: doc/BRIEF.md
# Interleaved Four-Register Vector Store Sequencer

This block executes a decoded vector store of four-element structures. It takes one command that names a first vector register, a base register and an optional post-index source. It then issues a stream of element-sized memory write requests. Those writes interleave the matching elements of four consecutive vector registers, so element e of all four registers lands in memory before element e+1 of any of them. Register numbering wraps modulo 32.

Vector width is 64 bits when `cmd_q` is 0 and 128 bits when it is 1. Element width is 8, 16, 32 or 64 bits, selected by `cmd_size`. The combination of 64-bit elements with a 64-bit vector is rejected as undefined. When post-indexing is requested, the block reports a base-register update after the last write has been accepted. The update adds either the total byte count of the transfer or the value of a second general register. Index 31 on the base port stands for the stack pointer.

The register files sit outside the block and are read combinationally. The base and offset reads are taken in the cycle the command is accepted. The vector read happens while each write is presented, and the vector file must stay unchanged while a command is in progress.

Top module: `vst4_store_seq`

## Requirements
- R1: An accepted legal command produces exactly 4 × elements writes, where elements = (64 << cmd_q) / (8 << cmd_size); this gives 32 writes for 8-bit elements in a 64-bit vector and 8 for 64-bit elements in a 128-bit vector.
- R2: cmd_size=3 with cmd_q=0 raises `ill_insn` for one cycle, in the cycle after acceptance, and produces no write and no writeback.
- R3: Writes follow element-major, register-minor order. Write number 4·e+s carries element e of register (cmd_rt+s) mod 32, and element e occupies vector bits [e·esize +: esize].
- R4: Register selection wraps modulo 32, so a first register of 30 uses registers 30, 31, 0 and 1.
- R5: The address of write k is the base value plus k × (element bytes). The base value is the general register `cmd_rn` sampled at acceptance.
- R6: `wr_data` carries the element in its low bits with zeros above, and `wr_be` sets its low (1 << cmd_size) bits and clears the rest.
- R7: With `cmd_post`=0, no writeback is reported.
- R8: With `cmd_post`=1 and `cmd_rm`=31, the writeback value is the base plus 32 (cmd_q=0) or 64 (cmd_q=1).
- R9: With `cmd_post`=1 and `cmd_rm`≠31, the writeback value is the base plus general register `cmd_rm`.
- R10: When `cmd_rn`=31, the base is read from index 31 of the base port, which is the stack pointer, and the writeback targets index 31.
- R11: `cmd_ready` is high only when the block is idle. The single-cycle writeback pulse comes only after the last write has been accepted.
- R12: While `wr_valid` is high and `wr_ready` is low, the request is held: valid stays high and address, data and byte enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_q | input | 1 | 0: 64-bit vectors, 1: 128-bit vectors |
| cmd_size | input | 2 | Element width code, width = 8 << code |
| cmd_rt | input | 5 | First vector register |
| cmd_rn | input | 5 | Base register index, 31 = stack pointer |
| cmd_rm | input | 5 | Post-index register, 31 = use transfer size |
| cmd_post | input | 1 | Post-index writeback requested |
| vrf_idx | output | 5 | Vector file read index |
| vrf_data | input | 128 | Vector file read data |
| gpr_base_idx | output | 5 | Base read index (follows cmd_rn) |
| gpr_base_data | input | 64 | Base read data |
| gpr_off_idx | output | 5 | Offset read index (follows cmd_rm) |
| gpr_off_data | input | 64 | Offset read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Byte address |
| wr_data | output | 64 | Element data, low-aligned |
| wr_be | output | 8 | Byte enables |
| ill_insn | output | 1 | Undefined-combination pulse |
| wb_valid | output | 1 | Base writeback pulse |
| wb_idx | output | 5 | Writeback register, 31 = stack pointer |
| wb_data | output | 64 | New base value |

## Verification
The hardest case to reach is a stall that arrives on the final write of the final element, just before the writeback. A fault there could fire the writeback early or shift the address stream by one element. The bench drives `wr_ready` from a per-command stall probability, up to heavy stalling, so that stalls land on every position including the last. It also runs commands whose register window crosses 31→0 and whose base is the stack pointer. Each such command feeds the updated base into the next one, so a wrong writeback value shows up again in the following address stream.

// File: rtl/vst4_pkg.sv
package vst4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_WBACK = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vst4_decode.sv
module vst4_decode #(
    parameter int VW      = 128,
    parameter int NSTRUCT = 4,
    parameter int AW      = 64,
    parameter int CNT_W   = $clog2(VW / 8) + 1
) (
    input  logic             q,
    input  logic [1:0]       size,
    output logic             illegal,
    output logic [CNT_W-1:0] elem_cnt,
    output logic [AW-1:0]    total
);

    localparam int VBYTES = VW / 8;

    logic [CNT_W-1:0] vec_bytes;

    always_comb begin
        vec_bytes = q ? CNT_W'(VBYTES) : CNT_W'(VBYTES / 2);
        elem_cnt  = vec_bytes >> size;
        total     = AW'(vec_bytes) * AW'(NSTRUCT);
        illegal   = (size == 2'd3) && !q;
    end

endmodule

// File: rtl/vst4_lane.sv
module vst4_lane #(
    parameter int VW     = 128,
    parameter int EW     = 64,
    parameter int EIDX_W = $clog2(VW / 8)
) (
    input  logic [VW-1:0]     vec,
    input  logic [EIDX_W-1:0] eidx,
    input  logic [1:0]        size,
    output logic [EW-1:0]     data,
    output logic [EW/8-1:0]   be
);

    localparam int SH_W = $clog2(VW) + 1;

    logic [SH_W-1:0]   shamt;
    logic [VW-1:0]     shifted;
    logic [EW-1:0]     cand  [4];
    logic [EW/8-1:0]   bcand [4];

    always_comb begin
        shamt   = SH_W'({eidx, 3'b000}) << size;
        shifted = vec >> shamt;
    end

    for (genvar g = 0; g < 4; g++) begin : g_width
        localparam int WB = 8 << g;
        if (WB <= EW) begin : g_fit
            localparam logic [EW/8-1:0] BEM = (EW/8)'((1 << (WB / 8)) - 1);
            assign cand[g]  = EW'(shifted[WB-1:0]);
            assign bcand[g] = BEM;
        end else begin : g_wide
            assign cand[g]  = '0;
            assign bcand[g] = '0;
        end
    end

    assign data = cand[size];
    assign be   = bcand[size];

endmodule

// File: rtl/vst4_store_seq.sv
module vst4_store_seq #(
    parameter int AW      = 64,
    parameter int VW      = 128,
    parameter int EW      = 64,
    parameter int NREG    = 32,
    parameter int NSTRUCT = 4,
    localparam int RI_W   = $clog2(NREG),
    localparam int BE_W   = EW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic            cmd_q,
    input  logic [1:0]      cmd_size,
    input  logic [RI_W-1:0] cmd_rt,
    input  logic [RI_W-1:0] cmd_rn,
    input  logic [RI_W-1:0] cmd_rm,
    input  logic            cmd_post,
    output logic [RI_W-1:0] vrf_idx,
    input  logic [VW-1:0]   vrf_data,
    output logic [RI_W-1:0] gpr_base_idx,
    input  logic [AW-1:0]   gpr_base_data,
    output logic [RI_W-1:0] gpr_off_idx,
    input  logic [AW-1:0]   gpr_off_data,
    output logic            wr_valid,
    input  logic            wr_ready,
    output logic [AW-1:0]   wr_addr,
    output logic [EW-1:0]   wr_data,
    output logic [BE_W-1:0] wr_be,
    output logic            ill_insn,
    output logic            wb_valid,
    output logic [RI_W-1:0] wb_idx,
    output logic [AW-1:0]   wb_data
);
    import vst4_pkg::*;

    localparam int EIDX_W = $clog2(VW / 8);
    localparam int CNT_W  = EIDX_W + 1;
    localparam int SUB_W  = (NSTRUCT > 1) ? $clog2(NSTRUCT) : 1;

    typedef struct packed {
        seq_state_e        st;
        logic [RI_W-1:0]   rt;
        logic [RI_W-1:0]   rn;
        logic [SUB_W-1:0]  sub;
        logic [EIDX_W-1:0] eidx;
        logic [EIDX_W-1:0] elast;
        logic [1:0]        size;
        logic              post;
        logic [AW-1:0]     base;
        logic [AW-1:0]     offs;
        logic [AW-1:0]     step;
        logic              undef;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic             dec_illegal;
    logic [CNT_W-1:0] dec_elems;
    logic [AW-1:0]    dec_total;
    logic [AW-1:0]    ebytes;

    vst4_decode #(
        .VW(VW), .NSTRUCT(NSTRUCT), .AW(AW), .CNT_W(CNT_W)
    ) u_decode (
        .q        (cmd_q),
        .size     (cmd_size),
        .illegal  (dec_illegal),
        .elem_cnt (dec_elems),
        .total    (dec_total)
    );

    vst4_lane #(
        .VW(VW), .EW(EW), .EIDX_W(EIDX_W)
    ) u_lane (
        .vec  (vrf_data),
        .eidx (cur_q.eidx),
        .size (cur_q.size),
        .data (wr_data),
        .be   (wr_be)
    );

    assign ebytes = AW'(1) << cur_q.size;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.undef = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (dec_illegal) begin
                        nxt_d.undef = 1'b1;
                    end else begin
                        nxt_d.st    = ST_SEND;
                        nxt_d.rt    = cmd_rt;
                        nxt_d.rn    = cmd_rn;
                        nxt_d.size  = cmd_size;
                        nxt_d.post  = cmd_post;
                        nxt_d.base  = gpr_base_data;
                        nxt_d.offs  = '0;
                        nxt_d.sub   = '0;
                        nxt_d.eidx  = '0;
                        nxt_d.elast = EIDX_W'(dec_elems - CNT_W'(1));
                        nxt_d.step  = (cmd_rm == RI_W'(NREG - 1)) ? dec_total : gpr_off_data;
                    end
                end
            end
            ST_SEND: begin
                if (wr_ready) begin
                    nxt_d.offs = cur_q.offs + ebytes;
                    if (cur_q.sub == SUB_W'(NSTRUCT - 1)) begin
                        nxt_d.sub = '0;
                        if (cur_q.eidx == cur_q.elast) begin
                            nxt_d.st = cur_q.post ? ST_WBACK : ST_IDLE;
                        end else begin
                            nxt_d.eidx = cur_q.eidx + EIDX_W'(1);
                        end
                    end else begin
                        nxt_d.sub = cur_q.sub + SUB_W'(1);
                    end
                end
            end
            ST_WBACK: nxt_d.st = ST_IDLE;
            default:  nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cmd_ready    = (cur_q.st == ST_IDLE);
    assign gpr_base_idx = cmd_rn;
    assign gpr_off_idx  = cmd_rm;
    assign vrf_idx      = cur_q.rt + RI_W'(cur_q.sub);
    assign wr_valid     = (cur_q.st == ST_SEND);
    assign wr_addr      = cur_q.base + cur_q.offs;
    assign ill_insn     = cur_q.undef;
    assign wb_valid     = (cur_q.st == ST_WBACK);
    assign wb_idx       = cur_q.rn;
    assign wb_data      = cur_q.base + cur_q.step;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_be)); // R12

    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ill_insn |-> !wr_valid && !wb_valid); // R2

    AST_WB_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !wr_valid && !cmd_ready); // R11

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !wr_valid); // R11

    AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $countones({1'b0, wr_be} + {{BE_W{1'b0}}, 1'b1}) == 1); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> !wr_valid ||
            (wr_addr == $past(wr_addr) + AW'($countones($past(wr_be))))); // R5

endmodule

// File: tb/vst4_store_seq_test.sv
module vst4_store_seq_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic         cmd_q = 1'b0;
    logic [1:0]   cmd_size = 2'd0;
    logic [4:0]   cmd_rt = 5'd0, cmd_rn = 5'd0, cmd_rm = 5'd0;
    logic         cmd_post = 1'b0;
    logic [4:0]   vrf_idx, gpr_base_idx, gpr_off_idx, wb_idx;
    logic [127:0] vrf_data;
    logic [63:0]  gpr_base_data, gpr_off_data;
    logic         wr_valid, wr_ready = 1'b0;
    logic [63:0]  wr_addr, wr_data, wb_data;
    logic [7:0]   wr_be;
    logic         ill_insn, wb_valid;

    logic [127:0] vrf [32];
    logic [63:0]  gpr [31];
    logic [63:0]  sp;

    always #4 clk = ~clk;

    assign vrf_data      = vrf[vrf_idx];
    assign gpr_base_data = (gpr_base_idx == 5'd31) ? sp : gpr[gpr_base_idx];
    assign gpr_off_data  = (gpr_off_idx == 5'd31) ? 64'd0 : gpr[gpr_off_idx];

    vst4_store_seq uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_q(cmd_q), .cmd_size(cmd_size), .cmd_rt(cmd_rt), .cmd_rn(cmd_rn),
        .cmd_rm(cmd_rm), .cmd_post(cmd_post),
        .vrf_idx(vrf_idx), .vrf_data(vrf_data),
        .gpr_base_idx(gpr_base_idx), .gpr_base_data(gpr_base_data),
        .gpr_off_idx(gpr_off_idx), .gpr_off_data(gpr_off_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .ill_insn(ill_insn), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    int n_chk = 0, n_fail = 0;
    logic [63:0] q_addr[$], q_data[$];
    logic [7:0]  q_be[$];
    int  stall_pct = 0;
    int  n_wr_seen = 0;
    bit  wb_seen = 0, und_seen = 0, exp_undef = 0, exp_wb = 0;
    logic [4:0]  exp_wb_idx;
    logic [63:0] exp_wb_data;
    bit  p_stall = 0;
    logic [63:0] p_addr, p_data;
    logic [7:0]  p_be;
    int  cycles = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference monitor: evaluated once per clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            wr_ready = ($urandom_range(99) >= stall_pct);
            if (wr_valid && cmd_ready) chk(0, "R11 ready while busy", 1, 0);
            if (wr_valid && p_stall) begin
                chk(wr_addr == p_addr && wr_data == p_data && wr_be == p_be,
                    "R12 held request", {wr_addr, wr_data}, {p_addr, p_data});
            end
            if (p_stall && !wr_valid) chk(0, "R12 valid dropped", 0, 1);
            if (wr_valid && wr_ready) begin
                n_wr_seen++;
                if (q_addr.size() == 0) begin
                    chk(0, "R1 extra write", n_wr_seen, 0);
                end else begin
                    logic [63:0] ea, ed;
                    logic [7:0]  eb;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    eb = q_be.pop_front();
                    chk(wr_addr == ea, "R5 address", wr_addr, ea);
                    chk(wr_data == ed, "R3 order/data", wr_data, ed);
                    chk(wr_be == eb, "R6 byte enables", wr_be, eb);
                end
            end
            p_stall = wr_valid && !wr_ready;
            p_addr = wr_addr; p_data = wr_data; p_be = wr_be;
            if (wb_valid) begin
                wb_seen = 1;
                chk(q_addr.size() == 0, "R11 writeback before last write", q_addr.size(), 0);
                chk(exp_wb && wb_idx == exp_wb_idx && wb_data == exp_wb_data,
                    "R8 R9 R10 writeback value", {wb_idx, wb_data}, {exp_wb_idx, exp_wb_data});
                if (wb_idx == 5'd31) sp = wb_data;
                else gpr[wb_idx] = wb_data;
            end
            if (ill_insn) begin
                und_seen = 1;
                chk(exp_undef, "R2 unexpected undefined flag", 1, 0);
            end
        end
    end

    task automatic run_cmd(input bit q, input logic [1:0] size, input logic [4:0] rt,
                           input logic [4:0] rn, input logic [4:0] rm, input bit post,
                           input int stall, input string wbreq);
        int elems, esize, ebytes, nexp;
        logic [63:0] base, off, mask;
        esize  = 8 << size;
        ebytes = esize / 8;
        elems  = (q ? 128 : 64) / esize;
        base   = (rn == 5'd31) ? sp : gpr[rn];
        mask   = (esize == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << esize) - 64'd1);
        exp_undef = (size == 2'd3) && !q;
        nexp = exp_undef ? 0 : 4 * elems;
        off = 0;
        if (!exp_undef) begin
            for (int e = 0; e < elems; e++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [4:0]   r;
                    logic [127:0] t;
                    r = rt + 5'(s);
                    t = vrf[r] >> (e * esize);
                    q_addr.push_back(base + off);
                    q_data.push_back(t[63:0] & mask);
                    q_be.push_back(8'((1 << ebytes) - 1));
                    off = off + 64'(ebytes);
                end
            end
        end
        exp_wb      = post && !exp_undef;
        exp_wb_idx  = rn;
        exp_wb_data = base + ((rm == 5'd31) ? (q ? 64'd64 : 64'd32) : gpr[rm]);
        n_wr_seen = 0; wb_seen = 0; und_seen = 0;
        stall_pct = stall;
        while (!cmd_ready) @(negedge clk);
        cmd_q = q; cmd_size = size; cmd_rt = rt; cmd_rn = rn; cmd_rm = rm;
        cmd_post = post; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(n_wr_seen == nexp, "R1 write count", n_wr_seen, nexp);
        chk(q_addr.size() == 0, "R1 missing writes", q_addr.size(), 0);
        chk(wb_seen == exp_wb, wbreq, wb_seen, exp_wb);
        chk(und_seen == exp_undef, "R2 undefined flag", und_seen, exp_undef);
        q_addr.delete(); q_data.delete(); q_be.delete();
    endtask

    initial begin
        for (int i = 0; i < 32; i++)
            vrf[i] = {$urandom(), $urandom(), $urandom(), $urandom()};
        for (int i = 0; i < 31; i++)
            gpr[i] = {32'h0000_1000 * 32'(i + 1), $urandom_range(255) << 4};
        sp = 64'h0000_7FFF_0000_0F00;
        repeat (3) @(negedge clk);
        chk(cmd_ready && !wr_valid && !wb_valid && !ill_insn, "R11 reset state",
            {cmd_ready, wr_valid, wb_valid, ill_insn}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        run_cmd(0, 2'd0, 5'd3,  5'd5,  5'd31, 0, 0,  "R7 no writeback");
        run_cmd(1, 2'd0, 5'd30, 5'd6,  5'd31, 1, 30, "R8 immediate writeback");   // R4 wrap
        run_cmd(1, 2'd1, 5'd12, 5'd31, 5'd31, 1, 20, "R10 stack pointer writeback");
        run_cmd(0, 2'd2, 5'd31, 5'd6,  5'd7,  1, 10, "R9 register writeback");    // R4 wrap
        run_cmd(1, 2'd3, 5'd29, 5'd31, 5'd2,  1, 40, "R10 stack pointer reg offset");
        run_cmd(0, 2'd3, 5'd1,  5'd4,  5'd31, 1, 0,  "R2 no writeback on undefined");
        run_cmd(1, 2'd2, 5'd28, 5'd6,  5'd9,  1, 80, "R12 heavy stall writeback");
        run_cmd(0, 2'd1, 5'd0,  5'd6,  5'd31, 0, 60, "R7 no writeback stalled");
        run_cmd(1, 2'd3, 5'd31, 5'd31, 5'd31, 1, 50, "R8 R10 sp immediate");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule